// File: doc/BRIEF.md
# Low-Power Mode Sequencing Controller

This block decides when a processor subsystem may enter and leave its low-power modes, and what the clock-control outputs must be in each mode. The core raises a one-cycle stop or wait request. The controller then gates the CPU clock, the peripheral clocks, the oscillator and the always-on timer domain. It keeps them in that state until a permitted wake event occurs. It then brings the system back to run, choosing the clock source that the exit path allows.

A stop request does not take effect at once while a nonvolatile-memory command is running. The controller parks in a pending state with every clock still running. If an unmasked interrupt arrives in that window, the stop is abandoned. A select bit, read at the moment the stop proceeds, picks between two stop depths. In the deep one the oscillator is switched off. In the shallow one the oscillator keeps running. A deep-stop exit can either wait for the oscillator to report ready, or, when fast wake is enabled, resume at once on the internal PLL clock. Oscillator start-up itself is modelled only by a ready input.

Top module: `lpm_seq_ctrl`

## Requirements
- R1: In run, a stop request with `nvm_busy` high moves the controller to the pending state on the next cycle. The pending code is 3'd2 and all four enables stay high. With `nvm_busy` low, the controller goes straight to a stop mode.
- R2: In pending, an interrupt wake returns the controller to run on the next cycle. An interrupt wake is `nmi` high, or any `irq` bit high whose `irq_mask` bit is 0. Otherwise the controller stays in pending while `nvm_busy` is high.
- R3: When a stop proceeds, the controller reads `pstop_sel` in that cycle. A value of 1 enters pseudo stop (code 3'd3) and 0 enters full stop (code 3'd4).
- R4: In full stop, `cpu_clk_en`, `per_clk_en`, `osc_en` and `aon_clk_en` are all 0.
- R5: In pseudo stop, `cpu_clk_en` and `per_clk_en` are 0, while `osc_en` and `aon_clk_en` are 1.
- R6: `wake_timer` or `wake_conv` ends either stop mode. These two inputs have no effect in run or in wait.
- R7: When full stop ends with `fast_wake_en` high, the controller enters run on the next cycle with `clk_src_pll` = 1, whatever `osc_ready` is. Later, in run, `osc_ready` high clears `clk_src_pll` to 0 on the next cycle.
- R8: In run, a wait request enters wait (code 3'd1) on the next cycle. Wait has `cpu_clk_en` = 0 and the other three enables = 1.
- R9: An interrupt wake ends wait and both stop modes. An `irq` bit whose mask bit is 1 has no effect in any mode.
- R10: When full stop ends with `fast_wake_en` low, the controller enters the oscillator-wait state (code 3'd5). In that state `osc_en` = 1 and the other three enables = 0. It stays there until `osc_ready` is high, then enters run with `clk_src_pll` = 0.
- R11: When `rst` is high at a clock edge, the controller goes to run (code 3'd0) with all four enables at 1 and `clk_src_pll` = 0. This overrides every other input in that cycle.
- R12: In run, a stop request and a wait request in the same cycle are handled as a stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| stop_req | input | 1 | One-cycle stop request from the core |
| wait_req | input | 1 | One-cycle wait request from the core |
| pstop_sel | input | 1 | 1 selects pseudo stop, 0 selects full stop |
| nvm_busy | input | 1 | Nonvolatile-memory command in progress |
| nmi | input | 1 | Non-maskable interrupt |
| irq | input | N_IRQ | Maskable interrupt requests |
| irq_mask | input | N_IRQ | Per-bit mask, 1 blocks the matching irq bit |
| wake_timer | input | 1 | Self-wake from the periodic wake timer |
| wake_conv | input | 1 | Self-wake from the converter |
| fast_wake_en | input | 1 | Leave full stop on the PLL clock at once |
| osc_ready | input | 1 | Oscillator has stabilised |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| osc_en | output | 1 | Oscillator enable |
| aon_clk_en | output | 1 | Enable for the timer, watchdog and converter domains |
| clk_src_pll | output | 1 | 1 when the system runs on the internal PLL clock |
| mode_code | output | 3 | Current mode code |

## Verification
The bench builds the block with `N_IRQ` = 4. This width is small enough to drive each interrupt line both masked and unmasked, and wide enough to show that one open bit among masked ones still wakes the controller. Its reference model follows each mode transition independently. It exercises every exit path, including oscillator-wait stretched over several cycles of low `osc_ready` and a fast-wake exit that later hands back to the oscillator. It also covers the case where memory stays busy for several cycles before the stop goes ahead.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

    // Mode codes; values are visible on mode_code
    typedef enum logic [2:0] {
        MD_RUN   = 3'd0,
        MD_WAIT  = 3'd1,
        MD_PEND  = 3'd2,
        MD_PSTOP = 3'd3,
        MD_FSTOP = 3'd4,
        MD_OSCW  = 3'd5
    } lpm_mode_e;

    typedef struct packed {
        lpm_mode_e mode;
        logic      pll_src;
    } lpm_regs_t;

    typedef struct packed {
        logic cpu;
        logic per;
        logic osc;
        logic aon;
    } lpm_enables_t;

endpackage

// File: rtl/lpm_wake_detect.sv
module lpm_wake_detect #(
    parameter int N_IRQ = 8
) (
    input  logic             nmi,
    input  logic [N_IRQ-1:0] irq,
    input  logic [N_IRQ-1:0] irq_mask,
    input  logic             wake_timer,
    input  logic             wake_conv,
    output logic             int_wake,
    output logic             self_wake
);

    logic [N_IRQ-1:0] open_hit;

    // one qualifying gate per interrupt line
    for (genvar gi = 0; gi < N_IRQ; gi++) begin : g_line
        assign open_hit[gi] = irq[gi] & ~irq_mask[gi];
    end

    assign int_wake  = nmi | (|open_hit);
    assign self_wake = wake_timer | wake_conv;

endmodule

// File: rtl/lpm_fsm.sv
module lpm_fsm
    import lpm_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      stop_req,
    input  logic      wait_req,
    input  logic      pstop_sel,
    input  logic      nvm_busy,
    input  logic      int_wake,
    input  logic      self_wake,
    input  logic      fast_wake_en,
    input  logic      osc_ready,
    output lpm_mode_e mode,
    output logic      pll_src
);

    lpm_regs_t r_q;
    lpm_regs_t r_d;

    always_comb begin
        r_d = r_q;
        unique case (r_q.mode)
            MD_RUN: begin
                if (r_q.pll_src && osc_ready) begin
                    r_d.pll_src = 1'b0;
                end
                if (stop_req) begin
                    if (nvm_busy) begin
                        r_d.mode = MD_PEND;
                    end else begin
                        r_d.mode = pstop_sel ? MD_PSTOP : MD_FSTOP;
                    end
                end else if (wait_req) begin
                    r_d.mode = MD_WAIT;
                end
            end
            MD_WAIT: begin
                if (int_wake) begin
                    r_d.mode = MD_RUN;
                end
            end
            MD_PEND: begin
                if (int_wake) begin
                    r_d.mode = MD_RUN;
                end else if (!nvm_busy) begin
                    r_d.mode = pstop_sel ? MD_PSTOP : MD_FSTOP;
                end
            end
            MD_PSTOP: begin
                if (int_wake || self_wake) begin
                    r_d.mode = MD_RUN;
                end
            end
            MD_FSTOP: begin
                if (int_wake || self_wake) begin
                    if (fast_wake_en) begin
                        r_d.mode    = MD_RUN;
                        r_d.pll_src = 1'b1;
                    end else begin
                        r_d.mode = MD_OSCW;
                    end
                end
            end
            MD_OSCW: begin
                if (osc_ready) begin
                    r_d.mode    = MD_RUN;
                    r_d.pll_src = 1'b0;
                end
            end
            default: begin
                r_d.mode    = MD_RUN;
                r_d.pll_src = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q.mode    <= MD_RUN;
            r_q.pll_src <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign mode    = r_q.mode;
    assign pll_src = r_q.pll_src;

endmodule

// File: rtl/lpm_clk_out.sv
module lpm_clk_out
    import lpm_pkg::*;
(
    input  lpm_mode_e    mode,
    output lpm_enables_t en
);

    always_comb begin
        unique case (mode)
            MD_RUN, MD_PEND: en = '{cpu: 1'b1, per: 1'b1, osc: 1'b1, aon: 1'b1};
            MD_WAIT:         en = '{cpu: 1'b0, per: 1'b1, osc: 1'b1, aon: 1'b1};
            MD_PSTOP:        en = '{cpu: 1'b0, per: 1'b0, osc: 1'b1, aon: 1'b1};
            MD_FSTOP:        en = '{cpu: 1'b0, per: 1'b0, osc: 1'b0, aon: 1'b0};
            MD_OSCW:         en = '{cpu: 1'b0, per: 1'b0, osc: 1'b1, aon: 1'b0};
            default:         en = '{cpu: 1'b1, per: 1'b1, osc: 1'b1, aon: 1'b1};
        endcase
    end

endmodule

// File: rtl/lpm_seq_ctrl.sv
module lpm_seq_ctrl
    import lpm_pkg::*;
#(
    parameter int N_IRQ = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             stop_req,
    input  logic             wait_req,
    input  logic             pstop_sel,
    input  logic             nvm_busy,
    input  logic             nmi,
    input  logic [N_IRQ-1:0] irq,
    input  logic [N_IRQ-1:0] irq_mask,
    input  logic             wake_timer,
    input  logic             wake_conv,
    input  logic             fast_wake_en,
    input  logic             osc_ready,
    output logic             cpu_clk_en,
    output logic             per_clk_en,
    output logic             osc_en,
    output logic             aon_clk_en,
    output logic             clk_src_pll,
    output logic [2:0]       mode_code
);

    logic         int_wake;
    logic         self_wake;
    lpm_mode_e    mode;
    lpm_enables_t en;

    lpm_wake_detect #(.N_IRQ(N_IRQ)) u_wake (
        .nmi        (nmi),
        .irq        (irq),
        .irq_mask   (irq_mask),
        .wake_timer (wake_timer),
        .wake_conv  (wake_conv),
        .int_wake   (int_wake),
        .self_wake  (self_wake)
    );

    lpm_fsm u_fsm (
        .clk          (clk),
        .rst          (rst),
        .stop_req     (stop_req),
        .wait_req     (wait_req),
        .pstop_sel    (pstop_sel),
        .nvm_busy     (nvm_busy),
        .int_wake     (int_wake),
        .self_wake    (self_wake),
        .fast_wake_en (fast_wake_en),
        .osc_ready    (osc_ready),
        .mode         (mode),
        .pll_src      (clk_src_pll)
    );

    lpm_clk_out u_out (
        .mode (mode),
        .en   (en)
    );

    assign cpu_clk_en = en.cpu;
    assign per_clk_en = en.per;
    assign osc_en     = en.osc;
    assign aon_clk_en = en.aon;
    assign mode_code  = mode;

endmodule

// File: rtl/lpm_seq_ctrl_chk.sv
module lpm_seq_ctrl_chk #(
    parameter int N_IRQ = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             stop_req,
    input logic             wait_req,
    input logic             nvm_busy,
    input logic             nmi,
    input logic [N_IRQ-1:0] irq,
    input logic [N_IRQ-1:0] irq_mask,
    input logic             wake_timer,
    input logic             wake_conv,
    input logic             fast_wake_en,
    input logic             osc_ready,
    input logic             cpu_clk_en,
    input logic             per_clk_en,
    input logic             osc_en,
    input logic             aon_clk_en,
    input logic             clk_src_pll,
    input logic [2:0]       mode_code
);

    logic iw;
    logic sw;
    assign iw = nmi | (|(irq & ~irq_mask));
    assign sw = wake_timer | wake_conv;

    a_r1_busy_holds_off: assert property (@(posedge clk) disable iff (rst)
        (mode_code == 3'd0 && stop_req && nvm_busy) |=> (mode_code == 3'd2 && cpu_clk_en && per_clk_en));

    a_r2_cancel_pending: assert property (@(posedge clk) disable iff (rst)
        (mode_code == 3'd2 && iw) |=> (mode_code == 3'd0));

    a_r4_full_stop_dark: assert property (@(posedge clk) disable iff (rst)
        (mode_code == 3'd4) |-> (!cpu_clk_en && !per_clk_en && !osc_en && !aon_clk_en));

    a_r5_pseudo_osc_on: assert property (@(posedge clk) disable iff (rst)
        (mode_code == 3'd3) |-> (!cpu_clk_en && !per_clk_en && osc_en && aon_clk_en));

    a_r7_fast_exit: assert property (@(posedge clk) disable iff (rst)
        (mode_code == 3'd4 && (iw || sw) && fast_wake_en) |=> (mode_code == 3'd0 && clk_src_pll));

    a_r8_wait_cpu_only: assert property (@(posedge clk) disable iff (rst)
        (mode_code == 3'd1) |-> (!cpu_clk_en && per_clk_en && osc_en && aon_clk_en));

    a_r9_wait_exit: assert property (@(posedge clk) disable iff (rst)
        (mode_code == 3'd1 && iw) |=> (mode_code == 3'd0));

    a_r10_osc_hold: assert property (@(posedge clk) disable iff (rst)
        (mode_code == 3'd5 && !osc_ready) |=> (mode_code == 3'd5 && osc_en && !cpu_clk_en));

    a_r11_reset_run: assert property (@(posedge clk)
        rst |=> (mode_code == 3'd0 && cpu_clk_en && per_clk_en && osc_en && aon_clk_en && !clk_src_pll));

    a_r12_stop_wins: assert property (@(posedge clk) disable iff (rst)
        (mode_code == 3'd0 && stop_req && wait_req) |=> (mode_code != 3'd1));

endmodule

bind lpm_seq_ctrl lpm_seq_ctrl_chk #(.N_IRQ(N_IRQ)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .stop_req     (stop_req),
    .wait_req     (wait_req),
    .nvm_busy     (nvm_busy),
    .nmi          (nmi),
    .irq          (irq),
    .irq_mask     (irq_mask),
    .wake_timer   (wake_timer),
    .wake_conv    (wake_conv),
    .fast_wake_en (fast_wake_en),
    .osc_ready    (osc_ready),
    .cpu_clk_en   (cpu_clk_en),
    .per_clk_en   (per_clk_en),
    .osc_en       (osc_en),
    .aon_clk_en   (aon_clk_en),
    .clk_src_pll  (clk_src_pll),
    .mode_code    (mode_code)
);

// File: tb/sim_lpm_seq_ctrl.sv
module sim_lpm_seq_ctrl;

    localparam int CLK_P = 10;
    localparam int NI    = 4;

    logic          clk = 1'b0;
    logic          rst, stop_req, wait_req, pstop_sel, nvm_busy, nmi;
    logic [NI-1:0] irq, irq_mask;
    logic          wake_timer, wake_conv, fast_wake_en, osc_ready;
    logic          cpu_clk_en, per_clk_en, osc_en, aon_clk_en, clk_src_pll;
    logic [2:0]    mode_code;

    int  vectors = 0;
    int  misses  = 0;
    bit  done    = 0;

    int  m_mode = 0;
    bit  m_pll  = 0;

    always #(CLK_P/2) clk = ~clk;

    lpm_seq_ctrl #(.N_IRQ(NI)) u0 (
        .clk(clk), .rst(rst), .stop_req(stop_req), .wait_req(wait_req),
        .pstop_sel(pstop_sel), .nvm_busy(nvm_busy), .nmi(nmi), .irq(irq),
        .irq_mask(irq_mask), .wake_timer(wake_timer), .wake_conv(wake_conv),
        .fast_wake_en(fast_wake_en), .osc_ready(osc_ready),
        .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .osc_en(osc_en),
        .aon_clk_en(aon_clk_en), .clk_src_pll(clk_src_pll), .mode_code(mode_code)
    );

    function automatic bit any_open();
        bit hit = nmi;
        for (int k = 0; k < NI; k++) begin
            if (irq[k] && !irq_mask[k]) hit = 1;
        end
        return hit;
    endfunction

    // behavioural reference, evaluated once per rising edge
    task automatic model_edge();
        bit iw = any_open();
        bit sw = wake_timer || wake_conv;
        if (rst) begin
            m_mode = 0; m_pll = 0;
        end else if (m_mode == 0) begin
            if (m_pll && osc_ready) m_pll = 0;
            if (stop_req) m_mode = nvm_busy ? 2 : (pstop_sel ? 3 : 4);
            else if (wait_req) m_mode = 1;
        end else if (m_mode == 1) begin
            if (iw) m_mode = 0;
        end else if (m_mode == 2) begin
            if (iw) m_mode = 0;
            else if (!nvm_busy) m_mode = pstop_sel ? 3 : 4;
        end else if (m_mode == 3) begin
            if (iw || sw) m_mode = 0;
        end else if (m_mode == 4) begin
            if (iw || sw) begin
                if (fast_wake_en) begin m_mode = 0; m_pll = 1; end
                else m_mode = 5;
            end
        end else begin
            if (osc_ready) begin m_mode = 0; m_pll = 0; end
        end
    endtask

    task automatic compare(string tag);
        logic [3:0] exp_en;
        logic [3:0] got_en;
        case (m_mode)
            0, 2:    exp_en = 4'b1111;
            1:       exp_en = 4'b0111;
            3:       exp_en = 4'b0011;
            4:       exp_en = 4'b0000;
            default: exp_en = 4'b0010;
        endcase
        got_en = {cpu_clk_en, per_clk_en, osc_en, aon_clk_en};
        vectors++;
        if (mode_code !== 3'(m_mode) || got_en !== exp_en || clk_src_pll !== m_pll) begin
            misses++;
            $display("FAIL %s: mode=%0d en=%b pll=%b expected mode=%0d en=%b pll=%b",
                     tag, mode_code, got_en, clk_src_pll, m_mode, exp_en, m_pll);
        end
    endtask

    task automatic cyc(string tag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare(tag);
    endtask

    task automatic idle();
        stop_req = 0; wait_req = 0; nmi = 0; irq = '0;
        wake_timer = 0; wake_conv = 0;
    endtask

    initial begin
        #(CLK_P * 5000);
        if (!done) begin
            misses++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    initial begin
        rst = 1; idle(); pstop_sel = 0; nvm_busy = 0; irq_mask = '1;
        fast_wake_en = 0; osc_ready = 0;
        @(negedge clk);
        cyc("R11 reset"); cyc("R11 reset");
        rst = 0;
        // R6: self-wake ignored in run
        wake_timer = 1; cyc("R6 run ignores timer"); idle();

        // R8 wait, R6/R9 ignore masked and self wake
        wait_req = 1; cyc("R8 enter wait"); idle();
        wake_conv = 1; cyc("R6 wait ignores conv"); idle();
        irq = 4'b0100; irq_mask = 4'b1111; cyc("R9 masked ignored"); idle();
        irq = 4'b0110; irq_mask = 4'b1011; cyc("R9 unmasked ends wait"); idle();
        cyc("R9 back in run");

        // R1/R3/R5 pending then pseudo stop
        nvm_busy = 1; pstop_sel = 1; stop_req = 1; cyc("R1 pending"); idle();
        for (int k = 0; k < 4; k++) cyc("R1 hold while busy");
        nvm_busy = 0; cyc("R3 pseudo stop after busy");
        for (int k = 0; k < 3; k++) cyc("R5 pseudo stop");
        wake_timer = 1; cyc("R6 timer ends pseudo"); idle();

        // R2 cancel
        nvm_busy = 1; stop_req = 1; cyc("R1 pending again"); idle();
        irq = 4'b0001; irq_mask = 4'b1110; cyc("R2 irq cancels"); idle();
        nvm_busy = 0; cyc("R2 stays run");

        // R12 + R3 full stop, R10 oscillator wait
        pstop_sel = 0; stop_req = 1; wait_req = 1; cyc("R12 stop wins"); idle();
        irq = 4'b1111; irq_mask = 4'b1111; cyc("R4 masked ignored in full stop"); idle();
        cyc("R4 full stop");
        wake_conv = 1; cyc("R10 to osc wait"); idle();
        for (int k = 0; k < 3; k++) cyc("R10 waiting for oscillator");
        osc_ready = 1; cyc("R10 resume run");
        osc_ready = 0;

        // R7 fast wake
        fast_wake_en = 1; stop_req = 1; cyc("R3 full stop"); idle();
        cyc("R4 full stop");
        nmi = 1; cyc("R7 fast wake to pll"); idle();
        cyc("R7 pll held"); cyc("R7 pll held");
        osc_ready = 1; cyc("R7 back to oscillator"); osc_ready = 0;

        // R9 nmi ends pseudo stop
        pstop_sel = 1; stop_req = 1; cyc("R3 pseudo"); idle();
        nmi = 1; cyc("R9 nmi ends pseudo"); idle();

        // R11 reset priority in full stop with fast-wake pll source
        pstop_sel = 0; stop_req = 1; cyc("R3 full"); idle();
        wake_timer = 1; cyc("R7 fast via timer"); idle();
        stop_req = 1; cyc("R3 full again"); idle();
        rst = 1; wake_conv = 1; stop_req = 1; cyc("R11 reset priority"); idle();
        rst = 0; cyc("R11 after reset");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

endmodule